// File: doc/BRIEF.md
# Single-Precision Compare, Min/Max and Sign-Injection Unit

This block takes two IEEE-754 single-precision operands and a three-bit operation code, and returns one 32-bit result and an invalid-operation flag. It covers three comparisons (equal, less-than, less-or-equal), minimum and maximum, and three ways of building a new sign for the first operand from the second. A comparison returns the integer 0 or 1. Every other operation returns a single-precision bit pattern. The block does no arithmetic and no rounding.

Each rule for not-a-number (NaN) operands is fixed by the operation:
- Ordered comparisons treat any NaN as invalid.
- Equality treats only a signalling NaN as invalid.
- Minimum and maximum discard a lone NaN.
- Sign injection never inspects the payload.

The decision logic is combinational and feeds one output register. Operands enter on a valid/ready handshake and results leave on a valid/ready handshake:
- An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- The result appears on the output one cycle after acceptance.
- While `out_valid` is high and `out_ready` is low, the result is held and `in_ready` drops. Back-pressure therefore stalls the producer without dropping or reordering results.
- A held result and a new input can trade places on the same edge, so the unit sustains one operation per cycle.

Top module: `fpcs_unit`

## Requirements
Operation codes on `in_op`: 0 equal, 1 less-than, 2 less-or-equal, 3 minimum, 4 maximum, 5 copy sign, 6 copy inverted sign, 7 XOR sign. The sign is bit 31, the exponent is bits 30:23 and the fraction is bits 22:0. A NaN has an exponent of all ones and a non-zero fraction. It is signalling when fraction bit 22 is 0.

- R1: Equality returns 1 exactly when neither operand is NaN and the two values are equal. +0 and -0 count as equal. The flag is raised only when an operand is a signalling NaN, and a quiet NaN simply gives 0.
- R2: Less-than and less-or-equal raise the flag and return 0 whenever either operand is any NaN.
- R3: For non-NaN operands, the ordered comparisons, minimum and maximum follow the real-number order. Positive values are ordered by magnitude, negative values by reversed magnitude, and every negative value lies below every positive value.
- R4: Minimum and maximum raise the flag when either operand is a signalling NaN. They return the other operand when exactly one operand is NaN. They return 0x7FC00000 when both operands are NaN.
- R5: Given one +0 and one -0 operand, in either order, minimum returns -0 and maximum returns +0.
- R6: Every sign-injection form returns bits 30:0 of the first operand. Bit 31 is the second operand's sign for code 5, its inverse for code 6, and the XOR of both signs for code 7.
- R7: Sign injection never raises the flag and passes NaN operands through bit for bit, apart from bit 31.
- R8: A comparison result has bits 31:1 equal to zero.
- R9: An accepted operation appears with `out_valid` high on the next clock edge.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_invalid` hold their values, `out_valid` stays high and `in_ready` is low.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and code are offered |
| in_ready | output | 1 | The unit can accept this cycle |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_op | input | 3 | Operation code |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result |
| out_data | output | 32 | Result value or 0/1 comparison |
| out_invalid | output | 1 | Invalid-operation flag for this result |

## Verification
Each result is registered once, so any wrong decision in the classifier, the order logic or the sign logic shows at the ports on the cycle after that operation is accepted. A mis-built ordering would show up at once as a wrong minimum or maximum between two negative values or between two zeros. A wrong NaN test would show as a flag raised or missed on one specific pair of special values. A wrong hold condition in the output stage would show as `out_data` changing while `out_ready` is low, or as a result lost during a stall. For that reason the special-value pairs are swept in full under every code, and a stall is applied separately.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;

  typedef enum logic [2:0] {
    OP_EQ   = 3'd0,
    OP_LT   = 3'd1,
    OP_LE   = 3'd2,
    OP_MIN  = 3'd3,
    OP_MAX  = 3'd4,
    OP_SGN  = 3'd5,
    OP_SGNN = 3'd6,
    OP_SGNX = 3'd7
  } fpcs_op_e;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
  } fpcs_cls_t;

endpackage

// File: rtl/fpcs_classify.sv
module fpcs_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] val,
  output fpcs_pkg::fpcs_cls_t  cls
);
  localparam int W = EXP_W + MAN_W + 1;

  logic exp_ones, exp_zero, man_zero;

  always_comb begin
    exp_ones = &val[W-2:MAN_W];
    exp_zero = ~|val[W-2:MAN_W];
    man_zero = ~|val[MAN_W-1:0];
    cls.nan  = exp_ones && !man_zero;
    // the top fraction bit marks a quiet NaN
    cls.snan = exp_ones && !man_zero && !val[MAN_W-1];
    cls.zero = exp_zero && man_zero;
  end
endmodule

// File: rtl/fpcs_order.sv
module fpcs_order #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  input  fpcs_pkg::fpcs_cls_t  ca,
  input  fpcs_pkg::fpcs_cls_t  cb,
  input  fpcs_pkg::fpcs_op_e   op,
  output logic [EXP_W+MAN_W:0] res,
  output logic                 flag
);
  import fpcs_pkg::*;
  localparam int W = EXP_W + MAN_W + 1;
  localparam logic [W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic mag_lt, mag_eq, both_zero, any_nan, any_snan;
  logic ord_lt, ord_eq, pick_a_min, pick_a_max;

  always_comb begin
    mag_lt    = a[W-2:0] < b[W-2:0];
    mag_eq    = a[W-2:0] == b[W-2:0];
    both_zero = ca.zero && cb.zero;
    any_nan   = ca.nan || cb.nan;
    any_snan  = ca.snan || cb.snan;

    // sign-magnitude order, NaN excluded by the callers
    if (both_zero)
      ord_lt = 1'b0;
    else if (a[W-1] != b[W-1])
      ord_lt = a[W-1];
    else if (!a[W-1])
      ord_lt = mag_lt;
    else
      ord_lt = !mag_lt && !mag_eq;

    ord_eq     = both_zero || (a == b);
    pick_a_min = ord_lt || (both_zero && a[W-1]);
    pick_a_max = !ord_lt && !(both_zero && b[W-1] == 1'b0 && a[W-1]);

    res  = '0;
    flag = 1'b0;
    unique case (op)
      OP_EQ: begin
        res[0] = !any_nan && ord_eq;
        flag   = any_snan;
      end
      OP_LT: begin
        res[0] = !any_nan && ord_lt;
        flag   = any_nan;
      end
      OP_LE: begin
        res[0] = !any_nan && (ord_lt || ord_eq);
        flag   = any_nan;
      end
      OP_MIN, OP_MAX: begin
        flag = any_snan;
        if (ca.nan && cb.nan)      res = CANON_NAN;
        else if (ca.nan)           res = b;
        else if (cb.nan)           res = a;
        else if (op == OP_MIN)     res = pick_a_min ? a : b;
        else                       res = pick_a_max ? a : b;
      end
      default: begin
        res  = '0;
        flag = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fpcs_sign_inject.sv
module fpcs_sign_inject #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  input  fpcs_pkg::fpcs_op_e   op,
  output logic [EXP_W+MAN_W:0] res
);
  import fpcs_pkg::*;
  localparam int W = EXP_W + MAN_W + 1;

  logic new_sign;

  always_comb begin
    unique case (op)
      OP_SGNN: new_sign = !b[W-1];
      OP_SGNX: new_sign = a[W-1] ^ b[W-1];
      default: new_sign = b[W-1];
    endcase
    res = {new_sign, a[W-2:0]};
  end
endmodule

// File: rtl/fpcs_unit.sv
module fpcs_unit #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [EXP_W+MAN_W:0]  in_a,
  input  logic [EXP_W+MAN_W:0]  in_b,
  input  logic [2:0]            in_op,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [EXP_W+MAN_W:0]  out_data,
  output logic                  out_invalid
);
  import fpcs_pkg::*;
  localparam int W = EXP_W + MAN_W + 1;

  fpcs_op_e  op;
  fpcs_cls_t cls [2];
  logic [W-1:0] opnd [2];
  logic [W-1:0] ord_res, sgn_res, nxt_data;
  logic         ord_flag, nxt_flag;

  assign op      = fpcs_op_e'(in_op);
  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fpcs_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val (opnd[i]),
      .cls (cls[i])
    );
  end

  fpcs_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .a    (in_a),
    .b    (in_b),
    .ca   (cls[0]),
    .cb   (cls[1]),
    .op   (op),
    .res  (ord_res),
    .flag (ord_flag)
  );

  fpcs_sign_inject #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sign (
    .a   (in_a),
    .b   (in_b),
    .op  (op),
    .res (sgn_res)
  );

  always_comb begin
    if (op == OP_SGN || op == OP_SGNN || op == OP_SGNX) begin
      nxt_data = sgn_res;
      nxt_flag = 1'b0;
    end else begin
      nxt_data = ord_res;
      nxt_flag = ord_flag;
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_invalid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data    <= nxt_data;
        out_invalid <= nxt_flag;
      end
    end
  end
endmodule

// File: rtl/fpcs_unit_chk.sv
module fpcs_unit_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [EXP_W+MAN_W:0] in_a,
  input logic [EXP_W+MAN_W:0] in_b,
  input logic [2:0]           in_op,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [EXP_W+MAN_W:0] out_data,
  input logic                 out_invalid
);
  localparam int W = EXP_W + MAN_W + 1;

  logic take, a_nan, b_nan, is_sgn, is_cmp, is_ord;
  assign take   = in_valid && in_ready;
  assign a_nan  = (&in_a[W-2:MAN_W]) && (|in_a[MAN_W-1:0]);
  assign b_nan  = (&in_b[W-2:MAN_W]) && (|in_b[MAN_W-1:0]);
  assign is_sgn = in_op >= 3'd5;
  assign is_cmp = in_op <= 3'd2;
  assign is_ord = in_op == 3'd1 || in_op == 3'd2;

  assert_ord_nan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_ord && (a_nan || b_nan) |=> out_invalid && out_data == '0);

  assert_sgn_mag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_sgn |=> out_data[W-2:0] == $past(in_a[W-2:0]));

  assert_sgn_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'd5 |=> out_data[W-1] == $past(in_b[W-1]));

  assert_sgn_noflag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_sgn |=> !out_invalid);

  assert_cmp_bool_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_cmp |=> out_data[W-1:1] == '0);

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_invalid));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind fpcs_unit fpcs_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (.*);

// File: tb/fpcs_unit_bench.sv
module fpcs_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [2:0]  in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_invalid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpcs_unit u_fpcs_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_invalid(out_invalid)
  );

  function automatic logic [31:0] sample_val(input int i);
    case (i)
      0:  return 32'h0000_0000;
      1:  return 32'h8000_0000;
      2:  return 32'h3F80_0000;
      3:  return 32'hBF80_0000;
      4:  return 32'h4000_0000;
      5:  return 32'hC000_0000;
      6:  return 32'h7F80_0000;
      7:  return 32'hFF80_0000;
      8:  return 32'h7FC0_0000;
      9:  return 32'hFFC1_2345;
      10: return 32'h7F80_0001;
      11: return 32'hFFA0_0000;
      12: return 32'h0000_0001;
      13: return 32'h8000_0001;
      14: return 32'h7F7F_FFFF;
      default: return 32'hBFC0_0000;
    endcase
  endfunction

  function automatic bit is_nan(input logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction

  function automatic bit is_snan(input logic [31:0] x);
    return is_nan(x) && !x[22];
  endfunction

  // real-number order key: signed magnitude mapped onto a signed integer line
  function automatic logic signed [33:0] order_key(input logic [31:0] x);
    logic signed [33:0] m;
    m = $signed({3'b000, x[30:0]});
    return x[31] ? -m : m;
  endfunction

  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [2:0] op);
    logic signed [33:0] ka, kb;
    bit na, nb, fl;
    logic [31:0] r;
    ka = order_key(a); kb = order_key(b);
    na = is_nan(a); nb = is_nan(b);
    fl = 1'b0; r = '0;
    case (op)
      3'd0: begin fl = is_snan(a) || is_snan(b); r = {31'd0, !na && !nb && ka == kb}; end
      3'd1: begin fl = na || nb; r = {31'd0, !fl && ka < kb}; end
      3'd2: begin fl = na || nb; r = {31'd0, !fl && ka <= kb}; end
      3'd3, 3'd4: begin
        fl = is_snan(a) || is_snan(b);
        if (na && nb) r = 32'h7FC0_0000;
        else if (na) r = b;
        else if (nb) r = a;
        else if (ka < kb) r = (op == 3'd3) ? a : b;
        else if (kb < ka) r = (op == 3'd3) ? b : a;
        else if (a == b) r = a;
        else r = (op == 3'd3) ? 32'h8000_0000 : 32'h0000_0000;
      end
      3'd5: r = {b[31], a[30:0]};
      3'd6: r = {~b[31], a[30:0]};
      default: r = {a[31] ^ b[31], a[30:0]};
    endcase
    return {fl, r};
  endfunction

  function automatic string req_tag(input logic [31:0] a, input logic [31:0] b,
                                    input logic [2:0] op);
    if (op == 3'd0) return "R1";
    if (op <= 3'd2) return (is_nan(a) || is_nan(b)) ? "R2" : "R3";
    if (op <= 3'd4) begin
      if (is_nan(a) || is_nan(b)) return "R4";
      if (a[30:0] == 0 && b[30:0] == 0) return "R5";
      return "R3";
    end
    return (is_nan(a) || is_nan(b)) ? "R7" : "R6";
  endfunction

  task automatic check(input bit ok, input string req, input logic [32:0] act,
                       input logic [32:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
    logic [32:0] exp;
    @(negedge clk);
    in_a = a; in_b = b; in_op = op; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(a, b, op);
    check(out_valid, "R9", {32'd0, out_valid}, 33'd1);
    check({out_invalid, out_data} == exp, req_tag(a, b, op), {out_invalid, out_data}, exp);
    if (op <= 3'd2)
      check(out_data[31:1] == 0, "R8", {1'b0, out_data}, {1'b0, exp[31:0]});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!out_valid && in_ready, "R11", {31'd0, out_valid, in_ready}, 33'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R11", {32'd0, out_valid}, 33'd0);

    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          run_one(sample_val(i), sample_val(j), 3'(op));

    // R10: back-pressure holds the result and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    in_a = 32'hC000_0000; in_b = 32'hBF80_0000; in_op = 3'd3; in_valid = 1'b1;
    @(negedge clk);
    in_a = 32'h3F80_0000; in_b = 32'h4000_0000; in_op = 3'd4;
    held = out_data;
    check(out_valid && out_data == 32'hC000_0000, "R10", {out_valid, out_data},
          {1'b1, 32'hC000_0000});
    check(!in_ready, "R10", {32'd0, in_ready}, 33'd0);
    repeat (3) @(negedge clk);
    check(out_valid && out_data == held, "R10", {out_valid, out_data}, {1'b1, held});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    // the pending max is taken once the stall ends
    check(out_valid && out_data == 32'h4000_0000, "R9", {out_valid, out_data},
          {1'b1, 32'h4000_0000});
    @(negedge clk);
    check(!out_valid, "R9", {32'd0, out_valid}, 33'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule